// File: doc/BRIEF.md
# Fixed-Point Chaotic Attractor Integrator

This block advances a three-variable chaotic convection system by explicit forward-Euler steps, entirely in signed fixed-point arithmetic. It keeps the state vector (x, y, z) in registers. For every step it forms the derivatives dx = sigma·(y − x), dy = x·(rho − z) − y and dz = x·y − beta·z. It scales each derivative by the step size h and adds the result to the matching state component. The three components are written together, and a one-cycle valid strobe marks each finished step.

Each step passes through five registered stages: differences, products, derivatives, step scaling and commit. Every intermediate value is registered in one cycle and read in the next. A step needs the state that the step before it produced, so only one step is ever in flight. Every multiply widens to 64 bits and is brought back to 32 bits by keeping a fixed slice that matches the Q8.24 format, with saturation whenever the slice cannot hold the value. A host seeds the state through the load inputs and holds the run input high for as long as the trajectory should advance.

Top module: `attractor_stepper`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, each state output takes its reset constant (default 1.0 in Q8.24, i.e. 16777216) and the valid output goes low.
- R2: All values are 32-bit two's complement Q8.24 (24 fraction bits). A product keeps bits [55:24] of the 64-bit full product, which equals the product shifted right by 24 with rounding toward minus infinity. From the default reset state with default constants (sigma 10, rho 28, beta 44739243, h 65536), the first step gives x = 16777216, y = 18481152, z = 16667989.
- R3: A product whose bits [63:55] are not all equal is replaced by 0x7FFFFFFF when positive and by 0x80000000 when negative.
- R4: Every addition and subtraction saturates to 0x7FFFFFFF or 0x80000000 on 32-bit overflow. This includes the final state update.
- R5: A step computes dx = sigma·(y−x), dy = x·(rho−z) − y and dz = x·y − beta·z from the current state. It then writes s + h·d to all three components in the same cycle.
- R6: When run is high at an edge where no step is in flight (and load is low), a step starts there, and valid is high in the cycle after the fifth edge counted from that start. While run is held high, steps complete every 5 cycles.
- R7: Valid is high for exactly one cycle per completed step. Between completions the state outputs change only through a load.
- R8: At an edge where no step is in flight, load high copies the seed inputs into the state and keeps a step from starting at that edge. Load while a step is in flight has no effect.
- R9: With run and load low and no step in flight, the state holds and valid stays low.
- R10: Over long trajectories (over 1000 steps) every step result equals, bit for bit, an integer model of the arithmetic in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Start a step whenever idle while high |
| load_i | input | 1 | Copy seeds into the state when idle |
| seed_x_i | input | 32 | Initial x, Q8.24 |
| seed_y_i | input | 32 | Initial y, Q8.24 |
| seed_z_i | input | 32 | Initial z, Q8.24 |
| x_o | output | 32 | Current x, Q8.24 |
| y_o | output | 32 | Current y, Q8.24 |
| z_o | output | 32 | Current z, Q8.24 |
| valid_o | output | 1 | One-cycle strobe after each committed step |

## Verification
The bench builds two copies side by side. One uses the default constants with h = 1/256, so it follows a genuine chaotic trajectory for over a thousand steps and reaches product saturation from extreme seeds. The other keeps the same coefficients but sets the step size to 1.0 (STEP_Q = 16777216). With that step size the scaled derivative becomes as large as the state itself, which brings overflow of the final state addition within reach; a small step can never produce that overflow.

// File: rtl/atr_pkg.sv
// Shared definitions for the attractor integrator: axis indices and the
// phase encoding of the step sequencer. Assumes exactly three state axes.
package atr_pkg;
    localparam int AXES = 3;
    localparam int AX_X = 0;
    localparam int AX_Y = 1;
    localparam int AX_Z = 2;

    // Phase names tell which stage register loads at the next edge.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_MUL    = 3'd1,
        PH_DERIV  = 3'd2,
        PH_SCALE  = 3'd3,
        PH_COMMIT = 3'd4
    } atr_phase_e;
endpackage

// File: rtl/atr_fx_mul.sv
// Fixed-point multiplier: full-width signed product, kept slice aligned to
// FRAC fraction bits, saturated when the discarded upper bits are not sign
// copies. Purely combinational; assumes FRAC < W.
module atr_fx_mul #(
    parameter int W    = 32,
    parameter int FRAC = 24
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW    = 2 * W;
    localparam int TOP   = FRAC + W - 1;
    localparam int GUARD = PW - TOP;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] full;
    logic [GUARD-1:0]     guard_bits;

    assign a_ext      = {{W{a[W-1]}}, a};
    assign b_ext      = {{W{b[W-1]}}, b};
    assign full       = a_ext * b_ext;
    assign guard_bits = full[PW-1:TOP];

    // Pick the aligned slice or the saturation limit of the product's sign.
    always_comb begin
        if ((guard_bits == '0) || (guard_bits == '1)) begin
            p = full[TOP:FRAC];
        end else if (full[PW-1]) begin
            p = {1'b1, {(W-1){1'b0}}};
        end else begin
            p = {1'b0, {(W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/atr_fx_addsub.sv
// Saturating signed adder or subtractor, variant chosen by SUB.
// Combinational; result clamps to the W-bit extremes on overflow.
module atr_fx_addsub #(
    parameter int W   = 32,
    parameter bit SUB = 1'b0
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] s
);
    logic signed [W:0] a_ext;
    logic signed [W:0] b_ext;
    logic signed [W:0] raw;

    assign a_ext = {a[W-1], a};
    assign b_ext = {b[W-1], b};

    generate
        if (SUB) begin : g_sub
            assign raw = a_ext - b_ext;
        end else begin : g_add
            assign raw = a_ext + b_ext;
        end
    endgenerate

    // Clamp when the two top bits of the widened result disagree.
    always_comb begin
        if (raw[W] == raw[W-1]) begin
            s = raw[W-1:0];
        end else if (raw[W]) begin
            s = {1'b1, {(W-1){1'b0}}};
        end else begin
            s = {1'b0, {(W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/atr_seq.sv
// Step sequencer: walks the five stage phases once per step, admits a load
// or a new step only while idle (load has priority) and raises the valid
// strobe for the cycle after the commit edge.
module atr_seq
    import atr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       load_i,
    output atr_phase_e phase_o,
    output logic       start_o,
    output logic       load_ok_o,
    output logic       busy_o,
    output logic       valid_o
);
    atr_phase_e phase_q;
    atr_phase_e phase_d;
    logic       valid_q;

    assign busy_o    = (phase_q != PH_IDLE);
    assign load_ok_o = !busy_o && load_i;
    assign start_o   = !busy_o && run_i && !load_i;
    assign phase_o   = phase_q;
    assign valid_o   = valid_q;

    // Next-phase choice: one stage per cycle, then back to idle.
    always_comb begin
        unique case (phase_q)
            PH_IDLE:   phase_d = start_o ? PH_MUL : PH_IDLE;
            PH_MUL:    phase_d = PH_DERIV;
            PH_DERIV:  phase_d = PH_SCALE;
            PH_SCALE:  phase_d = PH_COMMIT;
            PH_COMMIT: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            valid_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            valid_q <= (phase_q == PH_COMMIT);
        end
    end
endmodule

// File: rtl/attractor_stepper.sv
// Forward-Euler integrator of a three-variable chaotic system in Q(W-FRAC).FRAC
// fixed point. Five registered stages per step: differences, products,
// derivatives, step scaling, commit. Assumes the coefficients fit the format.
module attractor_stepper
    import atr_pkg::*;
#(
    parameter int                 W        = 32,
    parameter int                 FRAC     = 24,
    parameter logic signed [31:0] SIGMA_Q  = 32'sd167772160,
    parameter logic signed [31:0] RHO_Q    = 32'sd469762048,
    parameter logic signed [31:0] BETA_Q   = 32'sd44739243,
    parameter logic signed [31:0] STEP_Q   = 32'sd65536,
    parameter logic signed [31:0] INIT_X_Q = 32'sd16777216,
    parameter logic signed [31:0] INIT_Y_Q = 32'sd16777216,
    parameter logic signed [31:0] INIT_Z_Q = 32'sd16777216
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                load_i,
    input  logic signed [W-1:0] seed_x_i,
    input  logic signed [W-1:0] seed_y_i,
    input  logic signed [W-1:0] seed_z_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output logic signed [W-1:0] z_o,
    output logic                valid_o
);
    localparam int NPROD = 4;
    localparam logic signed [W-1:0] SIG_W  = W'(SIGMA_Q);
    localparam logic signed [W-1:0] RHO_W  = W'(RHO_Q);
    localparam logic signed [W-1:0] BETA_W = W'(BETA_Q);
    localparam logic signed [W-1:0] STEP_W = W'(STEP_Q);
    localparam logic signed [W-1:0] INIT_V [AXES] =
        '{W'(INIT_X_Q), W'(INIT_Y_Q), W'(INIT_Z_Q)};

    atr_phase_e phase;
    logic       start;
    logic       load_ok;
    logic       busy;

    atr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .load_i    (load_i),
        .phase_o   (phase),
        .start_o   (start),
        .load_ok_o (load_ok),
        .busy_o    (busy),
        .valid_o   (valid_o)
    );

    logic signed [W-1:0] st_q   [AXES];
    logic signed [W-1:0] seed_v [AXES];

    assign seed_v[AX_X] = seed_x_i;
    assign seed_v[AX_Y] = seed_y_i;
    assign seed_v[AX_Z] = seed_z_i;
    assign x_o = st_q[AX_X];
    assign y_o = st_q[AX_Y];
    assign z_o = st_q[AX_Z];

    // ---------------- stage 1: differences ----------------
    logic signed [W-1:0] dif_yx;
    logic signed [W-1:0] dif_rz;
    logic signed [W-1:0] dif_yx_q;
    logic signed [W-1:0] dif_rz_q;

    atr_fx_addsub #(.W(W), .SUB(1'b1)) u_dif_yx (
        .a(st_q[AX_Y]), .b(st_q[AX_X]), .s(dif_yx)
    );
    atr_fx_addsub #(.W(W), .SUB(1'b1)) u_dif_rz (
        .a(RHO_W), .b(st_q[AX_Z]), .s(dif_rz)
    );

    // Capture both differences on the edge that starts a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dif_yx_q <= '0;
            dif_rz_q <= '0;
        end else if (start) begin
            dif_yx_q <= dif_yx;
            dif_rz_q <= dif_rz;
        end
    end

    // ---------------- stage 2: products ----------------
    logic signed [W-1:0] mul_a  [NPROD];
    logic signed [W-1:0] mul_b  [NPROD];
    logic signed [W-1:0] mul_p  [NPROD];
    logic signed [W-1:0] prod_q [NPROD];

    assign mul_a[0] = SIG_W;       assign mul_b[0] = dif_yx_q;
    assign mul_a[1] = st_q[AX_X];  assign mul_b[1] = dif_rz_q;
    assign mul_a[2] = st_q[AX_X];  assign mul_b[2] = st_q[AX_Y];
    assign mul_a[3] = BETA_W;      assign mul_b[3] = st_q[AX_Z];

    generate
        for (genvar k = 0; k < NPROD; k++) begin : g_prod
            atr_fx_mul #(.W(W), .FRAC(FRAC)) u_mul (
                .a(mul_a[k]), .b(mul_b[k]), .p(mul_p[k])
            );

            // Hold the reduced product for the derivative stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prod_q[k] <= '0;
                end else if (phase == PH_MUL) begin
                    prod_q[k] <= mul_p[k];
                end
            end
        end
    endgenerate

    // ---------------- stage 3: derivatives ----------------
    logic signed [W-1:0] der_d [AXES];
    logic signed [W-1:0] der_q [AXES];

    assign der_d[AX_X] = prod_q[0];
    atr_fx_addsub #(.W(W), .SUB(1'b1)) u_der_y (
        .a(prod_q[1]), .b(st_q[AX_Y]), .s(der_d[AX_Y])
    );
    atr_fx_addsub #(.W(W), .SUB(1'b1)) u_der_z (
        .a(prod_q[2]), .b(prod_q[3]), .s(der_d[AX_Z])
    );

    // ---------------- stages 4 and 5, one lane per axis ----------------
    logic signed [W-1:0] scl_d [AXES];
    logic signed [W-1:0] scl_q [AXES];
    logic signed [W-1:0] nxt_d [AXES];

    generate
        for (genvar i = 0; i < AXES; i++) begin : g_lane
            // Register this axis' derivative.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    der_q[i] <= '0;
                end else if (phase == PH_DERIV) begin
                    der_q[i] <= der_d[i];
                end
            end

            atr_fx_mul #(.W(W), .FRAC(FRAC)) u_scale (
                .a(STEP_W), .b(der_q[i]), .p(scl_d[i])
            );

            // Register the step-scaled increment.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_q[i] <= '0;
                end else if (phase == PH_SCALE) begin
                    scl_q[i] <= scl_d[i];
                end
            end

            atr_fx_addsub #(.W(W), .SUB(1'b0)) u_acc (
                .a(st_q[i]), .b(scl_q[i]), .s(nxt_d[i])
            );

            // State register: reset constant, seed load, or committed update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q[i] <= INIT_V[i];
                end else if (load_ok) begin
                    st_q[i] <= seed_v[i];
                end else if (phase == PH_COMMIT) begin
                    st_q[i] <= nxt_d[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/atr_checker.sv
// Temporal checks on the integrator's ports and sequencer state; attached
// to every instance of the top module by the bind below.
module atr_checker #(
    parameter int W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_i,
    input logic                load_i,
    input logic                busy,
    input logic signed [W-1:0] seed_x_i,
    input logic signed [W-1:0] seed_y_i,
    input logic signed [W-1:0] seed_z_i,
    input logic signed [W-1:0] x_o,
    input logic signed [W-1:0] y_o,
    input logic signed [W-1:0] z_o,
    input logic                valid_o
);
    // R7: the strobe never lasts two cycles.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: state moves only at a completion or right after a load request.
    p_state_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(x_o) || !$stable(y_o) || !$stable(z_o)) |->
            (valid_o || $past(load_i)));

    // R6: a completion traces back to a run request five cycles earlier.
    p_start_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(run_i, 5) && !$past(load_i, 5)));

    // R8: an idle load lands the seeds in the state.
    p_load_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_i) |=>
            (x_o == $past(seed_x_i) && y_o == $past(seed_y_i) && z_o == $past(seed_z_i)));

    // R9: idle with no request keeps the state and the strobe quiet.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !run_i && !load_i) |=>
            ($stable(x_o) && $stable(y_o) && $stable(z_o) && !valid_o));
endmodule

bind attractor_stepper atr_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .load_i   (load_i),
    .busy     (busy),
    .seed_x_i (seed_x_i),
    .seed_y_i (seed_y_i),
    .seed_z_i (seed_z_i),
    .x_o      (x_o),
    .y_o      (y_o),
    .z_o      (z_o),
    .valid_o  (valid_o)
);

// File: tb/sim_attractor_stepper.sv
// Bench: u0 with default constants, u1 with step size 1.0, driven together
// and compared against an integer model of the fixed-point arithmetic.
module sim_attractor_stepper;
    localparam logic signed [31:0] ONE    = 32'sd16777216;
    localparam logic signed [31:0] QMAX   = 32'sh7fffffff;
    localparam logic signed [31:0] QMIN   = 32'sh80000000;
    localparam logic signed [31:0] K_SIG  = 32'sd167772160;
    localparam logic signed [31:0] K_RHO  = 32'sd469762048;
    localparam logic signed [31:0] K_BET  = 32'sd44739243;
    localparam logic signed [31:0] H_FINE = 32'sd65536;
    localparam logic signed [31:0] H_UNIT = 32'sd16777216;
    localparam int NVEC = 5;
    // {seed x, seed y, seed z, step count}
    localparam logic [127:0] VEC [NVEC] = '{
        {ONE, ONE, ONE, 32'd1000},
        {QMAX, QMIN, 32'h0, 32'd3},
        {32'h32000000, 32'h64000000, 32'h0, 32'd2},
        {32'hFC800000, 32'h07400000, 32'h14000000, 32'd60},
        {QMIN, QMIN, QMIN, 32'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic load = 1'b0;
    logic signed [31:0] sx = '0, sy = '0, sz = '0;
    logic signed [31:0] x0, y0, z0, x1, y1, z1;
    logic v0, v1;
    int checks = 0;
    int fails = 0;
    logic signed [31:0] mx [2];
    logic signed [31:0] my [2];
    logic signed [31:0] mz [2];

    always #5 clk = ~clk;

    attractor_stepper u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load),
        .seed_x_i(sx), .seed_y_i(sy), .seed_z_i(sz),
        .x_o(x0), .y_o(y0), .z_o(z0), .valid_o(v0)
    );

    attractor_stepper #(.STEP_Q(H_UNIT)) u1 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load),
        .seed_x_i(sx), .seed_y_i(sy), .seed_z_i(sz),
        .x_o(x1), .y_o(y1), .z_o(z1), .valid_o(v1)
    );

    function automatic logic signed [31:0] clamp(input longint v);
        if (v > 64'sd2147483647) return QMAX;
        if (v < -64'sd2147483648) return QMIN;
        return 32'(v);
    endfunction

    function automatic logic signed [31:0] f_mul(input logic signed [31:0] a, input logic signed [31:0] b);
        longint p;
        p = longint'(a) * longint'(b);
        return clamp(p >>> 24);
    endfunction

    function automatic logic signed [31:0] f_add(input logic signed [31:0] a, input logic signed [31:0] b, input bit sub);
        return clamp(sub ? longint'(a) - longint'(b) : longint'(a) + longint'(b));
    endfunction

    task automatic model_step(input int k);
        logic signed [31:0] h, dx, dy, dz;
        h  = (k == 0) ? H_FINE : H_UNIT;
        dx = f_mul(K_SIG, f_add(my[k], mx[k], 1'b1));
        dy = f_add(f_mul(mx[k], f_add(K_RHO, mz[k], 1'b1)), my[k], 1'b1);
        dz = f_add(f_mul(mx[k], my[k]), f_mul(K_BET, mz[k]), 1'b1);
        mx[k] = f_add(mx[k], f_mul(h, dx), 1'b0);
        my[k] = f_add(my[k], f_mul(h, dy), 1'b0);
        mz[k] = f_add(mz[k], f_mul(h, dz), 1'b0);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic cmp_model(input string tag);
        chk({tag, " u0.x"}, x0, mx[0]);
        chk({tag, " u0.y"}, y0, my[0]);
        chk({tag, " u0.z"}, z0, mz[0]);
        chk({tag, " u1.x"}, x1, mx[1]);
        chk({tag, " u1.y"}, y1, my[1]);
        chk({tag, " u1.z"}, z1, mz[1]);
    endtask

    // Count negedges until valid; flag any state motion seen before it.
    task automatic wait_valid(output int gap, output bit held);
        logic [191:0] snap;
        snap = {x0, y0, z0, x1, y1, z1};
        gap  = 0;
        held = 1'b1;
        do begin
            @(negedge clk);
            gap++;
            if (!v0 && ({x0, y0, z0, x1, y1, z1} !== snap)) held = 1'b0;
        end while (!v0 && gap < 40);
    endtask

    task automatic do_load(input logic signed [31:0] a, input logic signed [31:0] b, input logic signed [31:0] c);
        load = 1'b1; sx = a; sy = b; sz = c;
        @(negedge clk);
        load = 1'b0;
        chk("R8 load x", x0, a);
        chk("R8 load y", y0, b);
        chk("R8 load z", z1, c);
        for (int k = 0; k < 2; k++) begin
            mx[k] = a; my[k] = b; mz[k] = c;
        end
    endtask

    task automatic run_steps(input int n, input int e);
        int gap;
        bit held;
        run = 1'b1;
        for (int s = 0; s < n; s++) begin
            wait_valid(gap, held);
            if (s == n - 1) run = 1'b0;
            model_step(0);
            model_step(1);
            cmp_model("R10 trajectory");
            chk("R6 step period", gap, 5);
            chk("R7 state held between strobes", {31'd0, held}, 1);
            if (e == 1 && s == 0) chk("R3 product saturation x", x0, 32'sd2139095039);
            if (e == 2 && s == 0) chk("R4 update saturation x", x1, QMAX);
        end
    endtask

    // Watchdog: an overlong run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog act=timeout exp=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int gap;
        bit held;
        bit sawv;
        logic [127:0] v;
        repeat (3) @(negedge clk);
        chk("R1 reset x", x0, ONE);
        chk("R1 reset y", y0, ONE);
        chk("R1 reset z", z0, ONE);
        chk("R1 reset u1 x", x1, ONE);
        chk("R1 reset valid", {31'd0, v0}, 0);
        rst_n = 1'b1;

        // R9: idle without requests.
        sawv = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (v0 || v1) sawv = 1'b1;
        end
        chk("R9 no strobe when idle", {31'd0, sawv}, 0);
        chk("R9 idle x hold", x0, ONE);
        chk("R9 idle z hold", z0, ONE);
        for (int k = 0; k < 2; k++) begin
            mx[k] = ONE; my[k] = ONE; mz[k] = ONE;
        end

        // R2/R5/R6: first step from reset, hand-computed values.
        run = 1'b1;
        wait_valid(gap, held);
        run = 1'b0;
        chk("R6 first latency", gap, 5);
        chk("R2 first step x", x0, 32'sd16777216);
        chk("R2 first step y", y0, 32'sd18481152);
        chk("R5 first step z", z0, 32'sd16667989);
        model_step(0);
        model_step(1);
        cmp_model("R5 first step model");
        @(negedge clk);
        chk("R7 strobe one cycle", {31'd0, v0}, 0);

        // Vector table: seed, then run the listed number of steps.
        for (int e = 0; e < NVEC; e++) begin
            v = VEC[e];
            do_load(v[127:96], v[95:64], v[63:32]);
            run_steps(int'(v[31:0]), e);
            @(negedge clk);
        end

        // R8: load while a step is in flight is ignored.
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        load = 1'b1; sx = 32'sh05000000; sy = 32'sh05000000; sz = 32'sh05000000;
        @(negedge clk);
        load = 1'b0;
        wait_valid(gap, held);
        chk("R8 busy load left state alone", {31'd0, held}, 1);
        chk("R6 latency with mid-step load", gap, 3);
        model_step(0);
        model_step(1);
        cmp_model("R8 busy load ignored");
        repeat (4) @(negedge clk);
        cmp_model("R9 hold after step");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule